// File: doc/BRIEF.md
# Linear CCD Line Timing Generator

This block drives a linear CCD sensor that has separate even and odd outputs. All of its outputs come from the master clock. It makes the two complementary phase clocks, the per-pixel reset pulse and the once-per-line transfer pulse. It also makes two single-cycle strobes that tell the analog front end when to sample the black reference level and when to sample the signal level. Three flags mark each pixel as a dummy pixel, an optical-black pixel or an active pixel.

A pulse on `lineStart` while the block is idle starts one line. The line runs in this order:

1. a guard interval,
2. the transfer pulse,
3. a second guard interval,
4. pixel clocking, which stops after the last active pixel.

A pixel period is 20 master clocks. A phase counter steps through it, and every pulse edge and strobe is placed at a programmable phase within that period.

A small write port loads the configuration. Writes take effect only while no line is running.

Top module: `ccd_tgen`

## Requirements
- R1: After reset the block is idle (`busy`=0). The reset configuration is: RS position 10, RS width code 0, reference-sample position 14, signal-sample position 8, both extensions 0, control 0x3C, dummy count 1, black count 0, active count 4. In the idle state `phi1` is 1 when enabled, `phi2` is 0, `rsPulse` and `trPulse` sit at their inactive level, and every strobe and flag is 0.
- R2: Let the line-start edge be cycle 0. A `lineStart` high at a rising edge while idle gives, from that edge on, a guard of G=20+guardExt cycles, then a transfer window of T=20+trExt cycles in which `trPulse` is active, then a second guard of G cycles, then pixel clocking. `busy` is 1 from cycle 0 until the last pixel period ends.
- R3: During both guard intervals and the transfer window, `phi1` is held at 1 (when enabled) and `phi2` at 0.
- R4: In pixel clocking each pixel lasts 20 cycles with phase 0..19. `phi1` is 1 for phases 0..9 and 0 for phases 10..19, and `phi2` is its complement.
- R5: `rsPulse` is active in the phases p with rsPos <= p < rsPos+1+rsWidth. A width code of 0 gives a pulse exactly one cycle long.
- R6: `sampleRef` is 1 only in the phase equal to srPos, and `sampleSig` only in the phase equal to ssPos. Both happen only during pixel clocking.
- R7: Control bit 0 inverts RS and control bit 1 inverts TR. With the bit at 0 the pulse is active-high; with the bit at 1 the inactive level is 1.
- R8: Control bits 2, 3, 4 and 5 enable `phi1`, `phi2`, `rsPulse` and `trPulse` respectively. A disabled phase clock is held at 0, and a disabled RS or TR output is held at its inactive level.
- R9: Pixels are numbered from 1. A pixel is a dummy pixel (`dummyFlag`) while its number is below the dummy count D. A D of 0 acts as 1, so there are D-1 dummy pixels.
- R10: The B pixels that follow the dummy pixels raise `blackFlag`.
- R11: The A pixels that follow the black pixels raise `activeFlag`. After the last of them the block returns to idle. With no pixels at all, it returns to idle right after the second guard.
- R12: While `busy` is 1, configuration writes and `lineStart` are ignored. The line in progress, and the next line, run with the configuration held before the write.
- R13: The write address map is: 0 rsPos[4:0], 1 rsWidth[2:0], 2 srPos[4:0], 3 ssPos[4:0], 4 trExt[7:0], 5 guardExt[7:0], 6 control[5:0], 7 dummy count, 8 black count, 9 active count (counts [9:0]). All positions must be below 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| lineStart | input | 1 | Starts a line when sampled high while idle |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register address |
| cfgData | input | 16 | Configuration write data |
| phi1 | output | 1 | Phase clock 1 |
| phi2 | output | 1 | Phase clock 2 |
| rsPulse | output | 1 | Per-pixel reset pulse |
| trPulse | output | 1 | Line transfer pulse |
| sampleRef | output | 1 | Black-reference sample strobe |
| sampleSig | output | 1 | Signal sample strobe |
| dummyFlag | output | 1 | Current pixel is a dummy pixel |
| blackFlag | output | 1 | Current pixel is an optical-black pixel |
| activeFlag | output | 1 | Current pixel is an active pixel |
| busy | output | 1 | A line is in progress |

## Verification
The assertions take the programmed positions to be below the pixel period, so the phase compares and the single-cycle strobe checks stay meaningful. They also take the configuration to be steady whenever a line is running, which the register gate enforces. The stimulus draws every position modulo 20 and keeps the pixel counts small. It writes registers only while idle, except for deliberate writes and `lineStart` pulses made in the middle of a line. Those are placed well inside the first guard interval, and the line is then checked against the configuration that was in force before them.

// File: rtl/ccd_tgen_pkg.sv
package ccd_tgen_pkg;

  localparam int PIX_PERIOD = 20;
  localparam int POS_W      = 5;
  localparam int RSW_W      = 3;
  localparam int EXT_W      = 8;
  localparam int PIX_W      = 10;
  localparam int MIN_TR     = 20;
  localparam int MIN_GUARD  = 20;
  localparam int CFG_AW     = 4;
  localparam int CFG_DW     = 16;
  localparam int CTL_W      = 6;

  typedef struct packed {
    logic [POS_W-1:0] rsPos;
    logic [RSW_W-1:0] rsWidth;
    logic [POS_W-1:0] srPos;
    logic [POS_W-1:0] ssPos;
    logic [EXT_W-1:0] trExt;
    logic [EXT_W-1:0] guardExt;
    logic             trEn;
    logic             rsEn;
    logic             phi2En;
    logic             phi1En;
    logic             trInv;
    logic             rsInv;
    logic [PIX_W-1:0] dummyCnt;
    logic [PIX_W-1:0] blackCnt;
    logic [PIX_W-1:0] activeCnt;
  } cfg_t;

  typedef struct packed {
    logic             inPix;
    logic             trWin;
    logic [POS_W-1:0] phase;
    logic             isDummy;
    logic             isBlack;
    logic             isActive;
  } seq_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GUARD_A, ST_XFER, ST_GUARD_B, ST_PIXEL
  } st_t;

endpackage

// File: rtl/ccd_tgen_regs.sv
module ccd_tgen_regs
  import ccd_tgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              wrEn,
  input  logic [CFG_AW-1:0] wrAddr,
  input  logic [CFG_DW-1:0] wrData,
  output cfg_t              cfg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.rsPos     <= POS_W'(10);
      cfg.rsWidth   <= '0;
      cfg.srPos     <= POS_W'(14);
      cfg.ssPos     <= POS_W'(8);
      cfg.trExt     <= '0;
      cfg.guardExt  <= '0;
      cfg.rsInv     <= 1'b0;
      cfg.trInv     <= 1'b0;
      cfg.phi1En    <= 1'b1;
      cfg.phi2En    <= 1'b1;
      cfg.rsEn      <= 1'b1;
      cfg.trEn      <= 1'b1;
      cfg.dummyCnt  <= PIX_W'(1);
      cfg.blackCnt  <= '0;
      cfg.activeCnt <= PIX_W'(4);
    end else if (wrEn && !busy) begin
      case (wrAddr)
        CFG_AW'(0): cfg.rsPos     <= wrData[POS_W-1:0];
        CFG_AW'(1): cfg.rsWidth   <= wrData[RSW_W-1:0];
        CFG_AW'(2): cfg.srPos     <= wrData[POS_W-1:0];
        CFG_AW'(3): cfg.ssPos     <= wrData[POS_W-1:0];
        CFG_AW'(4): cfg.trExt     <= wrData[EXT_W-1:0];
        CFG_AW'(5): cfg.guardExt  <= wrData[EXT_W-1:0];
        CFG_AW'(6): {cfg.trEn, cfg.rsEn, cfg.phi2En, cfg.phi1En,
                     cfg.trInv, cfg.rsInv} <= wrData[CTL_W-1:0];
        CFG_AW'(7): cfg.dummyCnt  <= wrData[PIX_W-1:0];
        CFG_AW'(8): cfg.blackCnt  <= wrData[PIX_W-1:0];
        CFG_AW'(9): cfg.activeCnt <= wrData[PIX_W-1:0];
        default: ;
      endcase
    end
  end

  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cfg)); // R12

endmodule

// File: rtl/ccd_tgen_ctrl.sv
module ccd_tgen_ctrl
  import ccd_tgen_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lineStart,
  input  cfg_t cfg,
  output seq_t seq,
  output logic busy
);

  localparam int LEN_W = EXT_W + 1;
  localparam int SUM_W = PIX_W + 2;

  st_t              state;
  logic [LEN_W-1:0] lenCnt;
  logic [POS_W-1:0] phase;
  logic [SUM_W-1:0] pixNum;

  logic [LEN_W-1:0] guardLen, trLen, curLen;
  logic [SUM_W-1:0] dEff, blackEnd, lastPix;
  logic             lenDone, phaseWrap;

  always_comb begin
    guardLen  = LEN_W'(MIN_GUARD) + LEN_W'(cfg.guardExt);
    trLen     = LEN_W'(MIN_TR) + LEN_W'(cfg.trExt);
    curLen    = (state == ST_XFER) ? trLen : guardLen;
    lenDone   = (lenCnt == curLen - LEN_W'(1));
    phaseWrap = (phase == POS_W'(PIX_PERIOD - 1));
    dEff      = (cfg.dummyCnt == '0) ? SUM_W'(1) : SUM_W'(cfg.dummyCnt);
    blackEnd  = dEff + SUM_W'(cfg.blackCnt);
    lastPix   = blackEnd - SUM_W'(1) + SUM_W'(cfg.activeCnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      lenCnt <= '0;
      phase  <= '0;
      pixNum <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (lineStart) begin
            state  <= ST_GUARD_A;
            lenCnt <= '0;
          end
        end
        ST_GUARD_A, ST_XFER: begin
          if (lenDone) begin
            state  <= (state == ST_GUARD_A) ? ST_XFER : ST_GUARD_B;
            lenCnt <= '0;
          end else begin
            lenCnt <= lenCnt + LEN_W'(1);
          end
        end
        ST_GUARD_B: begin
          if (lenDone) begin
            lenCnt <= '0;
            phase  <= '0;
            pixNum <= SUM_W'(1);
            state  <= (lastPix == '0) ? ST_IDLE : ST_PIXEL;
          end else begin
            lenCnt <= lenCnt + LEN_W'(1);
          end
        end
        ST_PIXEL: begin
          if (phaseWrap) begin
            phase <= '0;
            if (pixNum == lastPix) state <= ST_IDLE;
            else pixNum <= pixNum + SUM_W'(1);
          end else begin
            phase <= phase + POS_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy         = (state != ST_IDLE);
    seq.inPix    = (state == ST_PIXEL);
    seq.trWin    = (state == ST_XFER);
    seq.phase    = phase;
    seq.isDummy  = seq.inPix && (pixNum < dEff);
    seq.isBlack  = seq.inPix && (pixNum >= dEff) && (pixNum < blackEnd);
    seq.isActive = seq.inPix && (pixNum >= blackEnd);
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    seq.inPix |-> (phase < POS_W'(PIX_PERIOD))); // R4
  AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({seq.isDummy, seq.isBlack, seq.isActive})); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XFER && lineStart) |=> (state != ST_GUARD_A)); // R12

endmodule

// File: rtl/ccd_tgen_dp.sv
module ccd_tgen_dp
  import ccd_tgen_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cfg_t cfg,
  input  seq_t seq,
  output logic phi1,
  output logic phi2,
  output logic rsPulse,
  output logic trPulse,
  output logic sampleRef,
  output logic sampleSig
);

  localparam int HALF = PIX_PERIOD / 2;

  logic             firstHalf, rsAct;
  logic [POS_W:0]   rsEnd;

  always_comb begin
    firstHalf = (seq.phase < POS_W'(HALF));
    rsEnd     = (POS_W+1)'(cfg.rsPos) + (POS_W+1)'(cfg.rsWidth) + (POS_W+1)'(1);
    rsAct     = seq.inPix && (seq.phase >= cfg.rsPos) &&
                ((POS_W+1)'(seq.phase) < rsEnd);
    phi1      = cfg.phi1En && (seq.inPix ? firstHalf : 1'b1);
    phi2      = cfg.phi2En && seq.inPix && !firstHalf;
    rsPulse   = cfg.rsEn ? (rsAct ^ cfg.rsInv) : cfg.rsInv;
    trPulse   = cfg.trEn ? (seq.trWin ^ cfg.trInv) : cfg.trInv;
    sampleRef = seq.inPix && (seq.phase == cfg.srPos);
    sampleSig = seq.inPix && (seq.phase == cfg.ssPos);
  end

  AST_PHI1_HELD: assert property (@(posedge clk) disable iff (rst)
    seq.trWin |-> $stable(phi1)); // R3
  AST_PHI_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    (seq.inPix && cfg.phi1En && cfg.phi2En) |-> (phi1 != phi2)); // R4
  AST_RS_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (cfg.rsWidth == '0 && $rose(rsAct)) |=> !rsAct); // R5
  AST_SR_ONE_MCLK: assert property (@(posedge clk) disable iff (rst)
    sampleRef |=> !sampleRef); // R6
  AST_SS_ONE_MCLK: assert property (@(posedge clk) disable iff (rst)
    sampleSig |=> !sampleSig); // R6

endmodule

// File: rtl/ccd_tgen.sv
module ccd_tgen
  import ccd_tgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lineStart,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_DW-1:0] cfgData,
  output logic              phi1,
  output logic              phi2,
  output logic              rsPulse,
  output logic              trPulse,
  output logic              sampleRef,
  output logic              sampleSig,
  output logic              dummyFlag,
  output logic              blackFlag,
  output logic              activeFlag,
  output logic              busy
);

  cfg_t cfg;
  seq_t seq;

  ccd_tgen_regs i_regs (
    .clk(clk), .rst(rst), .busy(busy), .wrEn(cfgWrEn),
    .wrAddr(cfgAddr), .wrData(cfgData), .cfg(cfg)
  );

  ccd_tgen_ctrl i_ctrl (
    .clk(clk), .rst(rst), .lineStart(lineStart), .cfg(cfg),
    .seq(seq), .busy(busy)
  );

  ccd_tgen_dp i_dp (
    .clk(clk), .rst(rst), .cfg(cfg), .seq(seq),
    .phi1(phi1), .phi2(phi2), .rsPulse(rsPulse), .trPulse(trPulse),
    .sampleRef(sampleRef), .sampleSig(sampleSig)
  );

  assign dummyFlag  = seq.isDummy;
  assign blackFlag  = seq.isBlack;
  assign activeFlag = seq.isActive;

endmodule

// File: tb/test_ccd_tgen.sv
module test_ccd_tgen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lineStart = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic phi1, phi2, rsPulse, trPulse, sampleRef, sampleSig;
  logic dummyFlag, blackFlag, activeFlag, busy;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  int mRs = 10, mRsW = 0, mSr = 14, mSs = 8, mTe = 0, mGe = 0;
  int mCtl = 'h3C, mD = 1, mB = 0, mA = 4;

  always #5 clk = ~clk;

  ccd_tgen i_ccd_tgen (
    .clk(clk), .rst(rst), .lineStart(lineStart), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .phi1(phi1), .phi2(phi2),
    .rsPulse(rsPulse), .trPulse(trPulse), .sampleRef(sampleRef),
    .sampleSig(sampleSig), .dummyFlag(dummyFlag), .blackFlag(blackFlag),
    .activeFlag(activeFlag), .busy(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bitOf(input int v, input int b);
    return (v >> b) & 1;
  endfunction

  // R13: address map drives the bench model
  task automatic setReg(input int addr, input int data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 4'(addr); cfgData = 16'(data);
    @(negedge clk);
    cfgWrEn = 1'b0;
    case (addr)
      0: mRs  = data & 31;
      1: mRsW = data & 7;
      2: mSr  = data & 31;
      3: mSs  = data & 31;
      4: mTe  = data & 255;
      5: mGe  = data & 255;
      6: mCtl = data & 63;
      7: mD   = data & 1023;
      8: mB   = data & 1023;
      9: mA   = data & 1023;
      default: ;
    endcase
  endtask

  task automatic checkIdle(input string note);
    chk({note, " R1 busy"}, busy, 0);
    chk({note, " R1 phi1"}, phi1, bitOf(mCtl, 2));
    chk({note, " R1 phi2"}, phi2, 0);
    chk({note, " R1 rs"}, rsPulse, bitOf(mCtl, 0));
    chk({note, " R1 tr"}, trPulse, bitOf(mCtl, 1));
    chk({note, " R1 strobes/flags"},
        {sampleRef, sampleSig, dummyFlag, blackFlag, activeFlag}, 0);
  endtask

  task automatic runLine(input string note, input bit midWrite, input bit midStart);
    int g, t, base, dE, nPix, total;
    g = 20 + mGe; t = 20 + mTe; base = 2 * g + t;
    dE = (mD == 0) ? 1 : mD;
    nPix = dE - 1 + mB + mA;
    total = base + 20 * nPix;
    @(negedge clk); lineStart = 1'b1;
    @(negedge clk); lineStart = 1'b0;
    for (int c = 0; c < total + 3; c++) begin
      bit inPix, trW, p1, p2, rsRaw, eRs, eTr;
      int k, ph, n;
      inPix = (c >= base) && (c < total);
      k = c - base; ph = inPix ? k % 20 : 0; n = inPix ? k / 20 + 1 : 0;
      trW = (c >= g) && (c < g + t);
      p1 = bitOf(mCtl, 2) != 0 && (inPix ? (ph < 10) : 1'b1);
      p2 = bitOf(mCtl, 3) != 0 && inPix && !(ph < 10);
      rsRaw = inPix && ph >= mRs && ph < mRs + 1 + mRsW;
      eRs = bitOf(mCtl, 4) != 0 ? (rsRaw ^ bitOf(mCtl, 0)) : bitOf(mCtl, 0);
      eTr = bitOf(mCtl, 5) != 0 ? (trW ^ bitOf(mCtl, 1)) : bitOf(mCtl, 1);
      chk({note, " R2 busy"}, busy, c < total);
      chk({note, inPix ? " R4 phi1" : " R3 phi1"}, phi1, p1);
      chk({note, inPix ? " R4 phi2" : " R3 phi2"}, phi2, p2);
      chk({note, " R5 R7 R8 rs"}, rsPulse, eRs);
      chk({note, " R2 R7 R8 tr"}, trPulse, eTr);
      chk({note, " R6 sampleRef"}, sampleRef, inPix && ph == mSr);
      chk({note, " R6 sampleSig"}, sampleSig, inPix && ph == mSs);
      chk({note, " R9 dummy"}, dummyFlag, inPix && n < dE);
      chk({note, " R10 black"}, blackFlag, inPix && n >= dE && n < dE + mB);
      chk({note, " R11 active"}, activeFlag, inPix && n >= dE + mB);
      if (c == 5 && midWrite) begin
        cfgWrEn = 1'b1; cfgAddr = 4'd0; cfgData = 16'd3;
      end
      if (c == 6 && midStart) lineStart = 1'b1;
      @(negedge clk);
      cfgWrEn = 1'b0; lineStart = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkIdle("reset");

    runLine("R13 defaults", 1'b0, 1'b0);

    setReg(7, 17); setReg(8, 2); setReg(9, 3);
    runLine("R9 dummy17", 1'b0, 1'b0);

    setReg(7, 0); setReg(8, 0); setReg(9, 1);
    setReg(0, 12); setReg(1, 7); setReg(4, 5); setReg(5, 3);
    runLine("R9 zero-dummy R5 wide", 1'b0, 1'b0);

    setReg(7, 1); setReg(8, 0); setReg(9, 0);
    runLine("R11 no-pixels", 1'b0, 1'b0);
    checkIdle("after empty");

    setReg(9, 2); setReg(6, 'h3F); setReg(0, 0); setReg(1, 0);
    runLine("R7 inverted", 1'b0, 1'b0);

    setReg(6, 'h03);
    runLine("R8 disabled", 1'b0, 1'b0);
    setReg(6, 'h14);
    runLine("R8 partial", 1'b0, 1'b0);

    setReg(6, 'h3C); setReg(0, 10);
    runLine("R12 midwrite", 1'b1, 1'b1);
    runLine("R12 after-ignored", 1'b0, 1'b0);
    setReg(0, 3);
    runLine("R13 rsPos written", 1'b0, 1'b0);

    for (int i = 0; i < 8; i++) begin
      setReg(0, $urandom % 20); setReg(1, $urandom % 8);
      setReg(2, $urandom % 20); setReg(3, $urandom % 20);
      setReg(4, $urandom % 16); setReg(5, $urandom % 16);
      setReg(6, $urandom % 64); setReg(7, $urandom % 6);
      setReg(8, $urandom % 4);  setReg(9, $urandom % 5);
      runLine("random", 1'b0, (i % 2) == 1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule